// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers five interrupt sources for a small CPU core: two active-low external pins, two timer overflow flags and a serial source formed from a receive flag and a transmit flag. It applies a global enable and per-source enables, sorts the surviving requests into a low and a high priority level, and presents one request with its vector address to the core. The core answers with a one-cycle acknowledge, and later with a one-cycle return pulse when the service routine ends.

Two in-service bits, one per level, control nesting. A high-level source may interrupt a low-level routine. A low-level source must wait while any low-level routine runs. Nothing interrupts a high-level routine. Inside one level a fixed order breaks ties. Each external pin passes through a synchronizer. A configuration bit makes that pin sense either a low level or a falling edge. In edge mode a pending flag latches the edge, and the acknowledge clears it.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every enable bit, priority bit and trigger bit is 0 (trigger 0 = level sensing), both in-service bits are clear, and `irq_req` stays low whatever the source inputs do.
- R2: While the master enable (`en_wdata[5]`) is 0, no request is presented.
- R3: A source whose enable bit is 0 is never selected. The enable bit positions are `en_wdata[0]` ext0, `[1]` timer 0, `[2]` ext1, `[3]` timer 1, `[4]` serial. The same bit positions are used for `prio_wdata`, where 1 means high level.
- R4: Among requests at the same level, the winner is the first in the order ext0, timer 0, ext1, timer 1, serial. The vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023 respectively.
- R5: When requests wait at both levels and no routine is in service, a high-level request wins.
- R6: A high-level request is presented during a low-level routine. A low-level request is held back during a low-level routine. No request is presented during a high-level routine.
- R7: With `trig_wdata[n]`=0, external pin n requests while it is low, two clock edges after the pin changes (two-flop synchronizer), and it stops requesting once the pin returns high.
- R8: With `trig_wdata[n]`=1, a high-then-low sample pair on pin n latches a pending request, which appears three clock edges after the fall. The request stays after the pin goes high again, and the acknowledge of that source clears it.
- R9: The serial source requests while either serial flag is 1. An acknowledge does not clear it.
- R10: An acknowledge of a presented request sets the in-service bit of the winner's level. A return pulse clears the high bit if it is set, and otherwise clears the low bit.
- R11: An acknowledge while no request is presented has no effect.
- R12: Timer overflow inputs are level requests that follow the input with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 timer 0) |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | Source enables [4:0], master enable [5] |
| prio_we | input | 1 | Write strobe for the priority register |
| prio_wdata | input | 5 | Per-source level, 1 = high |
| trig_we | input | 1 | Write strobe for the trigger register |
| trig_wdata | input | 2 | Per-pin sensing, 1 = falling edge |
| irq_req | output | 1 | Request to the CPU core |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| irq_reti | input | 1 | One-cycle return-from-interrupt pulse |

## Verification
The hardest state to reach is a nested stack. In it, a low-level routine is in service, a high-level routine sits above it, and more requests are still waiting at both levels. Only then can the return order and the blocking rules be told apart. The bench builds this stack step by step with timer and serial inputs, because these act without synchronizer delay. It acknowledges each winner, then sends return pulses one at a time and checks which waiting source appears after each pulse. Edge sensing is reached separately: a short low pulse on a pin is followed by a check that the request survives the pin's return to high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NEXT  = 2;              // external pins
  localparam int NSRC  = 2 * NEXT + 1;   // pins, timers, serial
  localparam int SRC_W = $clog2(NSRC);
  localparam int VEC_W = 16;
  localparam int EN_W  = NSRC + 1;       // source enables plus master

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
    return VEC_W'(3) + (VEC_W'(idx) << 3);
  endfunction
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q, pend_d;
  logic                   pin_s, fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_comb begin
    pend_d = pend_q;
    if (!edge_mode)  pend_d = 1'b0;
    else if (fall)   pend_d = 1'b1;
    else if (clr)    pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
      pend_q <= pend_d;
    end
  end

  assign req = edge_mode ? pend_q : ~pin_s;

  // R8: a latched flag only rises after a high sample
  p_edge_needs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(prev_q));
  // R8: acknowledge without a fresh edge empties the flag
  p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fall) |=> !pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  en_src,
  input  logic             master,
  input  logic [NSRC-1:0]  prio,
  input  logic             svc_hi,
  input  logic             svc_lo,
  output logic             grant_valid,
  output logic [SRC_W-1:0] grant_idx,
  output lvl_e             grant_lvl,
  output logic [NSRC-1:0]  grant_oh
);
  logic [NSRC-1:0] live, hi_cand, lo_cand, pick;

  always_comb begin
    live    = req & en_src & {NSRC{master}};
    hi_cand = live & prio;
    lo_cand = live & ~prio;
    pick      = '0;
    grant_lvl = LVL_LO;
    if (!svc_hi) begin
      if (|hi_cand) begin
        pick      = hi_cand;
        grant_lvl = LVL_HI;
      end else if (!svc_lo) begin
        pick = lo_cand;
      end
    end
    grant_oh  = '0;
    grant_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pick[i]) begin
        grant_oh    = '0;
        grant_oh[i] = 1'b1;
        grant_idx   = SRC_W'(i);
      end
    end
    grant_valid = |pick;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [NEXT-1:0]  tmr_ovf,
  input  logic             ser_rx_flag,
  input  logic             ser_tx_flag,
  input  logic             en_we,
  input  logic [EN_W-1:0]  en_wdata,
  input  logic             prio_we,
  input  logic [NSRC-1:0]  prio_wdata,
  input  logic             trig_we,
  input  logic [NEXT-1:0]  trig_wdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_reti
);
  logic [EN_W-1:0] en_q, en_d;
  logic [NSRC-1:0] prio_q, prio_d;
  logic [NEXT-1:0] trig_q, trig_d;
  logic [1:0]      svc_q, svc_d;     // [1] high level, [0] low level

  logic [NEXT-1:0]  ext_req;
  logic [NSRC-1:0]  src_req;
  logic             grant_valid;
  logic [SRC_W-1:0] grant_idx;
  lvl_e             grant_lvl;
  logic [NSRC-1:0]  grant_oh;
  logic             take;

  assign take = irq_ack & grant_valid;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    irq_ext_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[g]),
      .edge_mode (trig_q[g]),
      .clr       (take && grant_oh[2*g]),
      .req       (ext_req[g])
    );
  end

  always_comb begin
    for (int g = 0; g < NEXT; g++) begin
      src_req[2*g]   = ext_req[g];
      src_req[2*g+1] = tmr_ovf[g];
    end
    src_req[NSRC-1] = ser_rx_flag | ser_tx_flag;
  end

  irq_arbiter i_arb (
    .req         (src_req),
    .en_src      (en_q[NSRC-1:0]),
    .master      (en_q[EN_W-1]),
    .prio        (prio_q),
    .svc_hi      (svc_q[1]),
    .svc_lo      (svc_q[0]),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_lvl   (grant_lvl),
    .grant_oh    (grant_oh)
  );

  // next state
  always_comb begin
    en_d   = en_we   ? en_wdata   : en_q;
    prio_d = prio_we ? prio_wdata : prio_q;
    trig_d = trig_we ? trig_wdata : trig_q;
    svc_d  = svc_q;
    if (irq_reti) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (take) svc_d[grant_lvl] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
      trig_q <= '0;
      svc_q  <= '0;
    end else begin
      en_q   <= en_d;
      prio_q <= prio_d;
      trig_q <= trig_d;
      svc_q  <= svc_d;
    end
  end

  assign irq_req = grant_valid;
  assign irq_vec = grant_valid ? vec_of(grant_idx) : '0;

  p_master_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[EN_W-1] |-> !irq_req);
  p_hi_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q[1] |-> !irq_req);
  p_lo_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q[0] && irq_req) |-> ((prio_q & grant_oh) != '0));
  p_vec_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec < VEC_W'(8 * NSRC)));
  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));
  p_svc_from_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_q[0]) |-> $past(irq_ack));
  p_ret_hi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && svc_q[1] && !take) |=> (!svc_q[1] && svc_q[0] == $past(svc_q[0])));
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
  logic        en_we = 1'b0, prio_we = 1'b0, trig_we = 1'b0;
  logic [5:0]  en_wdata = '0;
  logic [4:0]  prio_wdata = '0;
  logic [1:0]  trig_wdata = '0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0, irq_reti = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .en_we(en_we), .en_wdata(en_wdata), .prio_we(prio_we), .prio_wdata(prio_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  typedef struct packed {
    logic [3:0]  rn;
    logic [5:0]  en;
    logic [4:0]  prio;
    logic [1:0]  ext;
    logic [1:0]  tmr;
    logic        rx;
    logic        tx;
    logic        req;
    logic [15:0] vec;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{4'd4,  6'h3F, 5'b00000, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 idle
    '{4'd4,  6'h3F, 5'b00000, 2'b11, 2'b11, 1'b0, 1'b0, 1'b1, 16'h000B}, // R4 timer0 over timer1
    '{4'd4,  6'h3F, 5'b00000, 2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 16'h0003}, // R4 ext0 first
    '{4'd4,  6'h3F, 5'b00000, 2'b01, 2'b10, 1'b1, 1'b0, 1'b1, 16'h0013}, // R4 ext1 over timer1
    '{4'd4,  6'h3F, 5'b00000, 2'b11, 2'b10, 1'b0, 1'b1, 1'b1, 16'h001B}, // R4 timer1 over serial
    '{4'd9,  6'h3F, 5'b00000, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 16'h0023}, // R9 receive flag
    '{4'd9,  6'h3F, 5'b00000, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 16'h0023}, // R9 transmit flag
    '{4'd2,  6'h1F, 5'b00000, 2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 16'h0000}, // R2 master off
    '{4'd3,  6'h3E, 5'b00000, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0013}, // R3 ext0 masked
    '{4'd5,  6'h3F, 5'b10000, 2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 16'h0023}, // R5 serial high
    '{4'd5,  6'h3F, 5'b01000, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 16'h001B}, // R5 timer1 high over ext0
    '{4'd3,  6'h30, 5'b00000, 2'b00, 2'b11, 1'b1, 1'b1, 1'b1, 16'h0023}  // R3 only serial enabled
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic exp_req, input logic [15:0] exp_vec);
    checks++;
    if (irq_req !== exp_req || (exp_req && irq_vec !== exp_vec)) begin
      fails++;
      $display("FAIL %s: req=%0b vec=%h, expected req=%0b vec=%h",
               rq, irq_req, irq_vec, exp_req, exp_vec);
    end
  endtask

  task automatic cfg(input logic [5:0] en, input logic [4:0] pr, input logic [1:0] tr);
    en_we = 1'b1; en_wdata = en;
    prio_we = 1'b1; prio_wdata = pr;
    trig_we = 1'b1; trig_wdata = tr;
    tick(1);
    en_we = 1'b0; prio_we = 1'b0; trig_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  task automatic reti();
    irq_reti = 1'b1; tick(1); irq_reti = 1'b0;
  endtask

  task automatic idle();
    ext_n = 2'b11; tmr_ovf = 2'b00; ser_rx_flag = 1'b0; ser_tx_flag = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: all sources active right after reset, nothing enabled
    ext_n = 2'b00; tmr_ovf = 2'b11; ser_rx_flag = 1'b1;
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset disables all", 1'b0, 16'h0);
    idle();
    tick(3);

    // R11: stray acknowledge must not mark a level busy
    cfg(6'h3F, 5'b00000, 2'b00);
    ack();
    tmr_ovf = 2'b01;
    tick(1);
    chk("R11 stray ack ignored", 1'b1, 16'h000B);
    idle();
    tick(1);

    // vector table, level sensing, nothing in service
    for (int r = 0; r < NROW; r++) begin
      cfg(TBL[r].en, TBL[r].prio, 2'b00);
      ext_n = TBL[r].ext; tmr_ovf = TBL[r].tmr;
      ser_rx_flag = TBL[r].rx; ser_tx_flag = TBL[r].tx;
      tick(3);
      chk($sformatf("R%0d table row %0d", TBL[r].rn, r), TBL[r].req, TBL[r].vec);
      idle();
      tick(3);
    end

    // R12: timer flags follow the input without delay
    cfg(6'h3F, 5'b00000, 2'b00);
    tmr_ovf = 2'b10; tick(1);
    chk("R12 timer1 level", 1'b1, 16'h001B);
    tmr_ovf = 2'b00; tick(1);
    chk("R12 timer1 released", 1'b0, 16'h0);

    // R7: level sensing through two-flop synchronizer
    ext_n = 2'b10; tick(1);
    chk("R7 sync latency", 1'b0, 16'h0);
    tick(1);
    chk("R7 pin low requests", 1'b1, 16'h0003);
    ext_n = 2'b11; tick(2);
    chk("R7 follows pin high", 1'b0, 16'h0);

    // nesting: timer1 and serial high, rest low
    cfg(6'h3F, 5'b11000, 2'b00);
    tmr_ovf = 2'b01; tick(1);
    chk("R6 low granted", 1'b1, 16'h000B);
    ack();
    chk("R6 low blocked by low service", 1'b0, 16'h0);
    ext_n = 2'b01; tick(3);
    chk("R6 second low waits", 1'b0, 16'h0);
    tmr_ovf = 2'b11; tick(1);
    chk("R6 high preempts low", 1'b1, 16'h001B);
    ack();
    tmr_ovf = 2'b01; tick(1);
    chk("R6 nothing during high", 1'b0, 16'h0);
    ser_rx_flag = 1'b1; tick(1);
    chk("R6 high blocked by high", 1'b0, 16'h0);
    reti();
    chk("R10 return clears high only", 1'b1, 16'h0023);
    ack();
    chk("R6 serial in service", 1'b0, 16'h0);
    reti();
    chk("R9 serial not cleared by ack", 1'b1, 16'h0023);
    ser_rx_flag = 1'b0; tick(1);
    chk("R10 low still in service", 1'b0, 16'h0);
    reti();
    chk("R10 second return clears low", 1'b1, 16'h000B);
    ack();
    idle();
    reti();
    tick(3);
    chk("R10 stack empty", 1'b0, 16'h0);

    // R8: falling-edge sensing on ext0
    cfg(6'h3F, 5'b00000, 2'b01);
    tick(2);
    ext_n = 2'b10; tick(1);
    chk("R8 not yet latched", 1'b0, 16'h0);
    tick(2);
    chk("R8 edge latched", 1'b1, 16'h0003);
    ext_n = 2'b11; tick(3);
    chk("R8 held after pin high", 1'b1, 16'h0003);
    ack();
    reti();
    chk("R8 cleared by ack", 1'b0, 16'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule